// File: doc/BRIEF.md
# Strap-Gated 64-bit Memory Window Decoder

This block holds one 64-bit base address register for a 1 MB prefetchable memory window in a bridge. The register is split across two configuration dwords: the low dword at offset 10h and the high dword at offset 14h. Together they supply address bits 63:20 of the window base. A static strap input switches the whole feature on or off. When the strap is low, the register is invisible: it reads as zero and ignores writes.

With the strap high and the memory-space enable bit set, the block compares each memory address seen on both sides of the bridge against the window. A match on the primary side is claimed, so the access is forwarded downstream. A match on the secondary side is flagged to be ignored, so the access is not passed back upstream. This lets private devices behind the bridge own memory that system software does not otherwise see.

Top module: `win_bar_decode`

## Requirements
- R1: After a synchronous reset, the stored base is zero, and `cfg_rdata`, `pri_claim` and `sec_ignore` are all 0.
- R2: While `bar_en_strap` is 0, a read of offset 10h or 14h returns 0.
- R3: While `bar_en_strap` is 0, writes to offsets 10h and 14h leave the stored base unchanged. This is seen by raising the strap again and reading the old value back.
- R4: With the strap high, the low dword (10h) reads as follows: bits 31:20 hold base bits 31:20, bits 19:4 are zero, and bits 3:0 are 1100b (64-bit prefetchable memory). The high dword (14h) reads base bits 63:32.
- R5: With the strap high, writing FFFFFFFFh to both dwords reads back FFF0000Ch at 10h and FFFFFFFFh at 14h. This is the 1 MB size mask.
- R6: A primary-side access with `pri_valid`=1 whose address bits 63:20 equal the base raises `pri_claim` on the next cycle. Any other access, or no access, leaves it 0.
- R7: A secondary-side access with `sec_valid`=1 whose address bits 63:20 equal the base raises `sec_ignore` on the next cycle. Any other access, or no access, leaves it 0.
- R8: No claim and no ignore is produced while `bar_en_strap` is 0 or `mem_space_en` is 0.
- R9: When the dual-address flag of a side is 0 (32-bit cycle), address bits 63:32 are taken as zero for the comparison.
- R10: Reads of any offset other than 10h or 14h return 0. Writes to other offsets do not change the base.
- R11: `cfg_rdata` is registered. It presents the dword selected by `cfg_addr` on the cycle after `cfg_rd`, and is 0 after any cycle without `cfg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bar_en_strap | input | 1 | Enables the window register and its decode |
| mem_space_en | input | 1 | Memory-space enable bit from the command register |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| pri_valid | input | 1 | Primary-side memory access present |
| pri_dac | input | 1 | Primary access uses a 64-bit address cycle |
| pri_addr | input | 64 | Primary-side memory address |
| pri_claim | output | 1 | Primary access falls in the window and is claimed |
| sec_valid | input | 1 | Secondary-side memory access present |
| sec_dac | input | 1 | Secondary access uses a 64-bit address cycle |
| sec_addr | input | 64 | Secondary-side memory address |
| sec_ignore | output | 1 | Secondary access falls in the window and is ignored |

## Verification
Probe addresses are derived from the current base in three ways:
- Flips confined to bits 19:0 must still match, which shows that the window is exactly 1 MB wide.
- A flip of a single bit in 63:20 must miss, which exposes any base bit the comparator drops.
- Clean 32-bit cycles carry stray upper bits. They separate correct zero-extension from comparing raw upper address bits.

Directed cases toggle the strap and the memory-space enable to show the gating. The same address is presented to both sides to show that they decide independently. Bases are written with random values and with all ones, so that the read-back layout and the size mask are checked against a bench model of the register.

// File: rtl/win_bar_pkg.sv
package win_bar_pkg;
  localparam int unsigned CFG_DW = 32;
  // type bits of the low dword: 64-bit decoder, prefetchable, memory space
  localparam logic [3:0] MEM64_PREF_TAG = 4'b1100;
endpackage

// File: rtl/win_bar_regs.sv
module win_bar_regs
  import win_bar_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned WIN_LSB = 20,
  parameter int unsigned OFF_W   = 8,
  parameter logic [OFF_W-1:0] LO_OFF = 8'h10,
  parameter logic [OFF_W-1:0] HI_OFF = 8'h14
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      strap,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [OFF_W-1:0]          addr,
  input  logic [CFG_DW-1:0]         wdata,
  output logic [CFG_DW-1:0]         rdata,
  output logic [ADDR_W-WIN_LSB-1:0] base
);
  localparam int unsigned BASE_W  = ADDR_W - WIN_LSB;
  localparam int unsigned LO_BITS = CFG_DW - WIN_LSB;
  localparam int unsigned HI_BITS = ADDR_W - CFG_DW;
  localparam int unsigned PAD_W   = WIN_LSB - 4;

  logic [BASE_W-1:0] base_q;
  logic [CFG_DW-1:0] rdata_q;
  logic [CFG_DW-1:0] lo_word, hi_word, rd_mux;
  logic              hit_lo, hit_hi;

  assign hit_lo  = (addr == LO_OFF);
  assign hit_hi  = (addr == HI_OFF);
  assign lo_word = {base_q[LO_BITS-1:0], {PAD_W{1'b0}}, MEM64_PREF_TAG};
  assign hi_word = base_q[BASE_W-1:LO_BITS];

  always_comb begin
    rd_mux = '0;
    if (strap) begin
      if (hit_lo)      rd_mux = lo_word;
      else if (hit_hi) rd_mux = hi_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && strap && hit_lo) base_q[LO_BITS-1:0]      <= wdata[CFG_DW-1:WIN_LSB];
      if (wr && strap && hit_hi) base_q[BASE_W-1:LO_BITS] <= wdata[HI_BITS-1:0];
      rdata_q <= rd ? rd_mux : '0;
    end
  end

  assign rdata = rdata_q;
  assign base  = base_q;

  // R2: strap low hides both dwords
  p_hidden_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && !strap) |=> (rdata == '0));
  // R3: strap low blocks writes
  p_locked_writes_r3: assert property (@(posedge clk) disable iff (rst)
    (wr && !strap) |=> $stable(base_q));
  // R4: low dword layout below the window bits
  p_low_layout_r4: assert property (@(posedge clk) disable iff (rst)
    (rd && strap && hit_lo) |=> (rdata[WIN_LSB-1:0] == {{PAD_W{1'b0}}, MEM64_PREF_TAG}));
  // R11: no read strobe, no data
  p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/win_bar_match.sv
module win_bar_match #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned WIN_LSB = 20
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enable,
  input  logic                      valid,
  input  logic                      dac,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-WIN_LSB-1:0] base,
  output logic                      hit
);
  localparam int unsigned HALF = 32;

  logic [ADDR_W-1:0] eff_addr;
  logic              hit_q;

  // single address cycle: upper half treated as zero
  assign eff_addr = dac ? addr : {{(ADDR_W-HALF){1'b0}}, addr[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= valid && enable && (eff_addr[ADDR_W-1:WIN_LSB] == base);
  end

  assign hit = hit_q;

  // R8: decode suppressed when gated off
  p_gated_off_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !hit_q);
  // R6: a decision needs an access
  p_needs_access_r6: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !hit_q);
endmodule

// File: rtl/win_bar_decode.sv
module win_bar_decode
  import win_bar_pkg::*;
#(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned WIN_LSB = 20,
  parameter int unsigned OFF_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bar_en_strap,
  input  logic              mem_space_en,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [OFF_W-1:0]  cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              pri_valid,
  input  logic              pri_dac,
  input  logic [ADDR_W-1:0] pri_addr,
  output logic              pri_claim,
  input  logic              sec_valid,
  input  logic              sec_dac,
  input  logic [ADDR_W-1:0] sec_addr,
  output logic              sec_ignore
);
  localparam int unsigned BASE_W = ADDR_W - WIN_LSB;
  localparam int unsigned SIDES  = 2;

  logic [BASE_W-1:0] base;
  logic              dec_en;
  logic [SIDES-1:0]  side_valid, side_dac, side_hit;
  logic [ADDR_W-1:0] side_addr [SIDES];

  assign dec_en     = bar_en_strap && mem_space_en;
  assign side_valid = {sec_valid, pri_valid};
  assign side_dac   = {sec_dac, pri_dac};
  assign side_addr[0] = pri_addr;
  assign side_addr[1] = sec_addr;

  win_bar_regs #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst(rst), .strap(bar_en_strap), .wr(cfg_wr), .rd(cfg_rd),
    .addr(cfg_addr), .wdata(cfg_wdata), .rdata(cfg_rdata), .base(base)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    win_bar_match #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_match (
      .clk(clk), .rst(rst), .enable(dec_en), .valid(side_valid[s]),
      .dac(side_dac[s]), .addr(side_addr[s]), .base(base), .hit(side_hit[s])
    );
  end

  assign pri_claim  = side_hit[0];
  assign sec_ignore = side_hit[1];

  // R7: secondary side acts only on its own access
  p_sec_own_access_r7: assert property (@(posedge clk) disable iff (rst)
    !sec_valid |=> !sec_ignore);
endmodule

// File: tb/win_bar_decode_test.sv
module win_bar_decode_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap = 1'b1, mem_en = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pri_valid = 1'b0, pri_dac = 1'b0, sec_valid = 1'b0, sec_dac = 1'b0;
  logic [63:0] pri_addr = '0, sec_addr = '0;
  logic        pri_claim, sec_ignore;

  int checks = 0;
  int fails  = 0;
  logic [63:0] mb = '0; // model: base, bits 19:0 zero

  always #4 clk = ~clk;

  win_bar_decode uut (
    .clk(clk), .rst(rst), .bar_en_strap(strap), .mem_space_en(mem_en),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pri_valid(pri_valid), .pri_dac(pri_dac),
    .pri_addr(pri_addr), .pri_claim(pri_claim), .sec_valid(sec_valid),
    .sec_dac(sec_dac), .sec_addr(sec_addr), .sec_ignore(sec_ignore)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (!strap) return 32'h0;
    if (a == 8'h10) return {mb[31:20], 16'h0, 4'hC};
    if (a == 8'h14) return mb[63:32];
    return 32'h0;
  endfunction

  function automatic logic exp_hit(input logic [63:0] a, input logic dac);
    logic [63:0] e;
    e = dac ? a : {32'h0, a[31:0]};
    return strap && mem_en && (e[63:20] == mb[63:20]);
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (strap && a == 8'h10) mb[31:20] = d[31:20];
    if (strap && a == 8'h14) mb[63:32] = d;
  endtask

  task automatic cfg_read(input string req, input logic [7:0] a);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd = 1'b0;
    chk(req, {32'h0, cfg_rdata}, {32'h0, exp_read(a)});
    @(negedge clk);
    chk("R11 idle", {32'h0, cfg_rdata}, 64'h0);
  endtask

  // side 0 primary, 1 secondary, 2 both with same address
  task automatic probe(input string req, input int side, input logic [63:0] a, input logic dac);
    @(negedge clk);
    pri_valid = (side != 1); sec_valid = (side != 0);
    pri_addr = a; sec_addr = a; pri_dac = dac; sec_dac = dac;
    @(negedge clk);
    pri_valid = 1'b0; sec_valid = 1'b0;
    chk({req, " pri"}, {63'h0, pri_claim},  {63'h0, (side != 1) && exp_hit(a, dac)});
    chk({req, " sec"}, {63'h0, sec_ignore}, {63'h0, (side != 0) && exp_hit(a, dac)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", {32'h0, cfg_rdata}, 64'h0);
    chk("R1 claim", {62'h0, pri_claim, sec_ignore}, 64'h0);
    cfg_read("R1 base lo", 8'h10);
    cfg_read("R1 base hi", 8'h14);
    // R5 size mask
    cfg_write(8'h10, 32'hFFFF_FFFF);
    cfg_write(8'h14, 32'hFFFF_FFFF);
    cfg_read("R5 lo mask", 8'h10);
    chk("R5 lo literal", {32'h0, exp_read(8'h10)}, 64'hFFF0_000C);
    cfg_read("R5 hi mask", 8'h14);
    // R4 layout with a distinct base
    cfg_write(8'h10, 32'hABCF_FFF3);
    cfg_write(8'h14, 32'h0000_0012);
    cfg_read("R4 lo layout", 8'h10);
    cfg_read("R4 hi", 8'h14);
    // R10 other offsets
    cfg_write(8'h18, 32'hDEAD_BEEF);
    cfg_write(8'h0C, 32'h1234_5678);
    cfg_read("R10 other", 8'h18);
    cfg_read("R10 lo kept", 8'h10);
    cfg_read("R10 hi kept", 8'h14);
    // R6 / R7 directed
    probe("R6 hit",  0, 64'h0000_0012_ABC0_0000, 1'b1);
    probe("R6 top",  0, 64'h0000_0012_ABCF_FFFF, 1'b1);
    probe("R6 miss", 0, 64'h0000_0012_ABD0_0000, 1'b1);
    probe("R7 hit",  1, 64'h0000_0012_ABC4_5678, 1'b1);
    probe("R7 miss", 1, 64'h0000_0013_ABC4_5678, 1'b1);
    probe("R6 R7 both", 2, 64'h0000_0012_ABC0_0010, 1'b1);
    // R9 32-bit cycle
    probe("R9 miss upper", 2, 64'h0000_0012_ABC0_0000, 1'b0);
    cfg_write(8'h14, 32'h0);
    probe("R9 stray upper", 2, 64'hFFFF_0000_ABC1_0000, 1'b0);
    probe("R9 dac stray", 2, 64'hFFFF_0000_ABC1_0000, 1'b1);
    // R8 gating
    mem_en = 1'b0;
    probe("R8 mem off", 2, 64'h0000_0000_ABC1_0000, 1'b1);
    mem_en = 1'b1;
    strap = 1'b0;
    probe("R8 strap off", 2, 64'h0000_0000_ABC1_0000, 1'b1);
    // R2 / R3
    cfg_read("R2 lo", 8'h10);
    cfg_read("R2 hi", 8'h14);
    cfg_write(8'h10, 32'h5550_0000);
    cfg_write(8'h14, 32'h0000_0077);
    strap = 1'b1;
    cfg_read("R3 lo kept", 8'h10);
    cfg_read("R3 hi kept", 8'h14);
    // random
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      logic        d;
      int          k;
      k = $urandom_range(0, 9);
      if (k == 0) begin
        cfg_write(8'h10, $urandom);
        cfg_write(8'h14, ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom);
        cfg_read("R4 rand lo", 8'h10);
      end else begin
        d = $urandom_range(0, 1);
        a = mb;
        if (k < 5)      a[19:0] = $urandom;
        else if (k < 8) a[$urandom_range(20, 63)] ^= 1'b1;
        else            a = {$urandom, $urandom};
        if (!d && $urandom_range(0, 1) == 1) a[63:32] = $urandom;
        probe(d ? "R6 R7 rand" : "R9 rand", $urandom_range(0, 2), a, d);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule